// File: doc/BRIEF.md
# Transfer Count and Command Register Block

This block keeps the programmable byte count for a storage-bus controller's transfers together with the register that launches its operations. The count is 24 bits wide and the host loads it one byte at a time into a shadow copy. The working copy, which is what the host reads back and what the transfer logic uses, changes only when a command arrives with its DMA flag set. At that point all three shadow bytes are copied across together.

The command register decodes each written byte into a DMA-mode level and, for recognised opcodes, a one-cycle strobe with the opcode. For a transfer-information command it also latches the effective transfer length. This length is the smaller of the working count and the size of the pending transfer, where a count of zero stands for 65536 bytes. The block also keeps the count-zero status flag. The data engine sets this flag through an event input.

Before the high count byte has been written for the first time after reset, a read of that byte returns a fixed identification value. The register bus uses one address for reads and writes. Reads are combinational.

Top module: `xfer_count_ctl`

## Requirements
- R1: After reset, config register 1 (address 0x8) reads 0x07. The low count byte (0x0), middle count byte (0x1), command register (0x3), status register (0x4) and every unmapped address read 0x00. `dma_mode` and `cmd_stb` are low.
- R2: A write to a count byte address (0x0 low, 0x1 middle, 0x2 high) changes only the shadow copy. Reads of the count bytes keep returning the working value until a reload happens.
- R3: A command write with bit 7 set drives `dma_mode` high from the next cycle. In the same edge it copies all three shadow bytes into the working count, which is assembled as low + middle<<8 + high<<16.
- R4: A command write with bit 7 clear drives `dma_mode` low from the next cycle and leaves the working count unchanged.
- R5: Status bit 4 is the count-zero flag. A cycle with `tc_event` high sets it. A write to any count byte clears it, and the clear wins over a set in the same cycle.
- R6: A transfer-information command written with bit 7 set clears the count-zero flag. The same command without bit 7 leaves the flag as it was.
- R7: A read of address 0x2 returns the `CHIP_ID` parameter until address 0x2 has been written once after reset. After that it returns the working high byte.
- R8: On a transfer-information command (opcode 0x10), `xfer_len` takes min(C, |P|). C is the working count in effect after that same write (reloaded first if bit 7 is set), with 0 read as 65536. P is `pend_size`, a signed value that is negative for outbound transfers.
- R9: The opcode is bits 6:0 of the command byte. For the opcodes 0x00–0x03, 0x10–0x12, 0x18 and 0x41–0x45, `cmd_stb` is high for the one cycle after the write and `cmd_op` carries the opcode. Any other opcode produces no strobe. Address 0x3 reads back the last command byte written.
- R10: `xfer_len` holds its value across every write other than a transfer-information command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 4 | Register address for reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| tc_event | input | 1 | Count-zero event from the data engine |
| pend_size | input | 26 | Signed pending transfer size, negative when outbound |
| dma_mode | output | 1 | High while the last command carried the DMA flag |
| cmd_stb | output | 1 | One-cycle strobe for a recognised opcode |
| cmd_op | output | 7 | Opcode belonging to the strobe |
| xfer_len | output | 25 | Effective length of the last transfer-information command |

## Verification
The bench reads the count bytes after shadow writes. A design that wrote straight into the working copy would show the new value early. It checks that a DMA-flagged transfer-information command uses the freshly reloaded count and not the previous one, and that a zero count gives 65536 rather than 0. It also drives a negative pending size, which a design without the magnitude step would treat as a huge or tiny number. Finally, it checks the identification read-back before and after the first high-byte write, and that an undefined opcode gives no strobe while still updating the DMA level.

// File: rtl/xfc_pkg.sv
package xfc_pkg;

    localparam int NBYTES   = 3;
    localparam int CNT_W    = 8 * NBYTES;
    localparam int LEN_W    = CNT_W + 1;
    localparam int PEND_W   = LEN_W + 1;
    localparam int ADDR_W   = 4;
    localparam int ZERO_LEN = 65536;

    localparam logic [ADDR_W-1:0] A_CNT_LO = 4'h0;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 4'h2;
    localparam logic [ADDR_W-1:0] A_CMD    = 4'h3;
    localparam logic [ADDR_W-1:0] A_STAT   = 4'h4;
    localparam logic [ADDR_W-1:0] A_CFG1   = 4'h8;

    localparam logic [7:0] CFG1_RST = 8'h07;
    localparam int         TZ_BIT   = 4;

    typedef enum logic [6:0] {
        OP_NOP        = 7'h00,
        OP_FLUSH      = 7'h01,
        OP_RESET      = 7'h02,
        OP_BUS_RESET  = 7'h03,
        OP_XFER       = 7'h10,
        OP_COMPLETE   = 7'h11,
        OP_MSG_ACCEPT = 7'h12,
        OP_PAD        = 7'h18,
        OP_SEL        = 7'h41,
        OP_SEL_ATN    = 7'h42,
        OP_SEL_STOP   = 7'h43,
        OP_SEL_ON     = 7'h44,
        OP_SEL_OFF    = 7'h45
    } xfc_op_e;

    typedef struct packed {
        logic       dma;
        logic [6:0] op;
    } xfc_cmd_t;

    function automatic logic is_known_op(input logic [6:0] op);
        case (op)
            OP_NOP, OP_FLUSH, OP_RESET, OP_BUS_RESET, OP_XFER, OP_COMPLETE,
            OP_MSG_ACCEPT, OP_PAD, OP_SEL, OP_SEL_ATN, OP_SEL_STOP,
            OP_SEL_ON, OP_SEL_OFF: return 1'b1;
            default:               return 1'b0;
        endcase
    endfunction

    function automatic logic [PEND_W-1:0] magnitude(input logic signed [PEND_W-1:0] p);
        return p[PEND_W-1] ? PEND_W'(-p) : PEND_W'(p);
    endfunction

endpackage

// File: rtl/xfc_count_regs.sv
module xfc_count_regs
    import xfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              reload,
    input  logic              tc_event,
    input  logic              xfer_dma,
    output logic [CNT_W-1:0]  shadow,
    output logic [CNT_W-1:0]  working,
    output logic              hi_written,
    output logic              tz_flag
);

    logic [7:0] shadow_b  [NBYTES];
    logic [7:0] working_b [NBYTES];
    logic       cnt_wr;

    always_comb begin
        cnt_wr = 1'b0;
        for (int b = 0; b < NBYTES; b++) begin
            if (wr && addr == A_CNT_LO + ADDR_W'(b)) cnt_wr = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < NBYTES; b++) begin
                shadow_b[b]  <= '0;
                working_b[b] <= '0;
            end
        end else begin
            for (int b = 0; b < NBYTES; b++) begin
                if (wr && addr == A_CNT_LO + ADDR_W'(b)) shadow_b[b] <= wdata;
                if (reload) working_b[b] <= shadow_b[b];
            end
        end
    end

    for (genvar g = 0; g < NBYTES; g++) begin : g_pack
        assign shadow[g*8 +: 8]  = shadow_b[g];
        assign working[g*8 +: 8] = working_b[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_written <= 1'b0;
            tz_flag    <= 1'b0;
        end else begin
            if (wr && addr == A_CNT_HI) hi_written <= 1'b1;
            if (cnt_wr || xfer_dma)  tz_flag <= 1'b0;
            else if (tc_event)       tz_flag <= 1'b1;
        end
    end

    // R5
    count_clr_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> !tz_flag);

    // R6
    xfer_clr_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_dma |=> !tz_flag);

endmodule

// File: rtl/xfc_cmd_decode.sv
module xfc_cmd_decode
    import xfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        cmd_byte,
    output logic              dma_mode,
    output logic              cmd_stb,
    output logic [6:0]        cmd_op,
    output logic              reload,
    output logic              xfer_now,
    output logic              xfer_dma
);

    xfc_cmd_t in_cmd;
    logic     cmd_wr;

    assign in_cmd   = xfc_cmd_t'(wdata);
    assign cmd_wr   = wr && (addr == A_CMD);
    assign reload   = cmd_wr && in_cmd.dma;
    assign xfer_now = cmd_wr && (in_cmd.op == OP_XFER);
    assign xfer_dma = xfer_now && in_cmd.dma;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_byte <= '0;
            dma_mode <= 1'b0;
            cmd_stb  <= 1'b0;
            cmd_op   <= '0;
        end else begin
            cmd_stb <= 1'b0;
            if (cmd_wr) begin
                cmd_byte <= wdata;
                dma_mode <= in_cmd.dma;
                if (is_known_op(in_cmd.op)) begin
                    cmd_stb <= 1'b1;
                    cmd_op  <= in_cmd.op;
                end
            end
        end
    end

    // R3
    dma_mode_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_wr |=> dma_mode == $past(wdata[7]));

    // R9
    stb_known_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_stb |-> is_known_op(cmd_op));

endmodule

// File: rtl/xfc_len_calc.sv
module xfc_len_calc
    import xfc_pkg::*;
(
    input  logic [CNT_W-1:0]         count,
    input  logic signed [PEND_W-1:0] pend,
    output logic [LEN_W-1:0]         len
);

    logic [LEN_W-1:0]  eff;
    logic [PEND_W-1:0] mag;

    always_comb begin
        eff = (count == '0) ? LEN_W'(ZERO_LEN) : LEN_W'(count);
        mag = magnitude(pend);
        if ({1'b0, eff} < mag) len = eff;
        else                   len = mag[LEN_W-1:0];
    end

endmodule

// File: rtl/xfer_count_ctl.sv
module xfer_count_ctl
    import xfc_pkg::*;
#(
    parameter logic [7:0] CHIP_ID = 8'h12
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     reg_wr,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [7:0]               reg_wdata,
    output logic [7:0]               reg_rdata,
    input  logic                     tc_event,
    input  logic signed [PEND_W-1:0] pend_size,
    output logic                     dma_mode,
    output logic                     cmd_stb,
    output logic [6:0]               cmd_op,
    output logic [LEN_W-1:0]         xfer_len
);

    logic [CNT_W-1:0] shadow, working, len_count;
    logic [LEN_W-1:0] len_next;
    logic [7:0]       cmd_byte, cfg1;
    logic             reload, xfer_now, xfer_dma, hi_written, tz_flag;

    xfc_cmd_decode u_cmd (
        .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .cmd_byte(cmd_byte), .dma_mode(dma_mode), .cmd_stb(cmd_stb),
        .cmd_op(cmd_op), .reload(reload), .xfer_now(xfer_now), .xfer_dma(xfer_dma)
    );

    xfc_count_regs u_cnt (
        .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .reload(reload), .tc_event(tc_event), .xfer_dma(xfer_dma),
        .shadow(shadow), .working(working), .hi_written(hi_written),
        .tz_flag(tz_flag)
    );

    assign len_count = reload ? shadow : working;

    xfc_len_calc u_len (
        .count(len_count), .pend(pend_size), .len(len_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            xfer_len <= '0;
            cfg1     <= CFG1_RST;
        end else begin
            if (xfer_now) xfer_len <= len_next;
            if (reg_wr && reg_addr == A_CFG1) cfg1 <= reg_wdata;
        end
    end

    always_comb begin
        case (reg_addr)
            A_CNT_LO:     reg_rdata = working[7:0];
            A_CNT_LO + 1: reg_rdata = working[15:8];
            A_CNT_HI:     reg_rdata = hi_written ? working[23:16] : CHIP_ID;
            A_CMD:        reg_rdata = cmd_byte;
            A_STAT:       reg_rdata = 8'(tz_flag) << TZ_BIT;
            A_CFG1:       reg_rdata = cfg1;
            default:      reg_rdata = '0;
        endcase
    end

    // R4
    work_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == A_CMD && !reg_wdata[7]) |=> $stable(working));

    // R8
    len_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_stb && cmd_op == OP_XFER) |-> {1'b0, xfer_len} <= magnitude($past(pend_size)));

    // R10
    len_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !xfer_now |=> $stable(xfer_len));

endmodule

// File: tb/test_xfer_count_ctl.sv
`timescale 1ns/1ps
module test_xfer_count_ctl;
    import xfc_pkg::*;

    localparam logic [7:0] ID = 8'h12;

    logic                     clk = 0;
    logic                     rst;
    logic                     reg_wr;
    logic [ADDR_W-1:0]        reg_addr;
    logic [7:0]               reg_wdata;
    logic [7:0]               reg_rdata;
    logic                     tc_event;
    logic signed [PEND_W-1:0] pend_size;
    logic                     dma_mode, cmd_stb;
    logic [6:0]               cmd_op;
    logic [LEN_W-1:0]         xfer_len;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    xfer_count_ctl #(.CHIP_ID(ID)) i_xfer_count_ctl (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tc_event(tc_event),
        .pend_size(pend_size), .dma_mode(dma_mode), .cmd_stb(cmd_stb),
        .cmd_op(cmd_op), .xfer_len(xfer_len)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        reg_addr = a; #0.5;
        d = reg_rdata;
    endtask

    task automatic pulse_tc();
        @(negedge clk); tc_event = 1;
        @(negedge clk); tc_event = 0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(4'h0, v); check("R1 lo", v, 0);
        rd(4'h1, v); check("R1 mid", v, 0);
        rd(4'h3, v); check("R1 cmd", v, 0);
        rd(4'h4, v); check("R1 stat", v, 0);
        rd(4'h8, v); check("R1 cfg1", v, 8'h07);
        rd(4'h5, v); check("R1 unmapped", v, 0);
        check("R1 dma_mode", dma_mode, 0);
        check("R1 cmd_stb", cmd_stb, 0);
        rd(4'h2, v); check("R7 id before write", v, ID);
    endtask

    task automatic t_shadow();
        logic [7:0] v;
        wr(4'h0, 8'h34); wr(4'h1, 8'h12); wr(4'h2, 8'h00);
        rd(4'h0, v); check("R2 lo unchanged", v, 0);
        rd(4'h1, v); check("R2 mid unchanged", v, 0);
        rd(4'h2, v); check("R7 hi after write", v, 0);
    endtask

    task automatic t_reload();
        logic [7:0] v;
        wr(4'h2, 8'h56);
        wr(4'h3, 8'h80);
        check("R9 stb nop", cmd_stb, 1);
        check("R9 op nop", cmd_op, 7'h00);
        check("R3 dma_mode", dma_mode, 1);
        rd(4'h0, v); check("R3 lo", v, 8'h34);
        rd(4'h1, v); check("R3 mid", v, 8'h12);
        rd(4'h2, v); check("R3 hi", v, 8'h56);
        @(posedge clk); #1;
        check("R9 stb one cycle", cmd_stb, 0);
        wr(4'h2, 8'h00);
        wr(4'h3, 8'h80);
    endtask

    task automatic t_nodma();
        logic [7:0] v;
        wr(4'h0, 8'h55);
        wr(4'h3, 8'h00);
        check("R4 dma_mode", dma_mode, 0);
        rd(4'h0, v); check("R4 lo held", v, 8'h34);
        rd(4'h3, v); check("R9 cmd readback", v, 8'h00);
    endtask

    task automatic t_flag();
        logic [7:0] v;
        pulse_tc();
        rd(4'h4, v); check("R5 set", v, 8'h10);
        wr(4'h1, 8'h12);
        rd(4'h4, v); check("R5 clear", v, 0);
        @(negedge clk); tc_event = 1; reg_wr = 1; reg_addr = 4'h1; reg_wdata = 8'h12;
        @(posedge clk); #1; reg_wr = 0; tc_event = 0;
        rd(4'h4, v); check("R5 clear wins", v, 0);
    endtask

    task automatic t_xfer();
        logic [7:0] v;
        pulse_tc();
        pend_size = 26'sd256;
        wr(4'h3, 8'h10);
        check("R8 min pend", xfer_len, 25'h100);
        check("R9 op xfer", cmd_op, 7'h10);
        rd(4'h4, v); check("R6 flag kept non-dma", v, 8'h10);
        pend_size = -26'sd8192;
        wr(4'h3, 8'h90);
        check("R8 reloaded count, negative pend", xfer_len, 25'h1255);
        rd(4'h4, v); check("R6 flag cleared dma", v, 0);
    endtask

    task automatic t_zero();
        wr(4'h0, 8'h00); wr(4'h1, 8'h00); wr(4'h2, 8'h00);
        pend_size = 26'sd131072;
        wr(4'h3, 8'h90);
        check("R8 zero is 65536", xfer_len, 25'h10000);
        pend_size = -26'sd5;
        wr(4'h3, 8'h10);
        check("R8 small outbound", xfer_len, 25'd5);
    endtask

    task automatic t_unknown();
        logic [7:0] v;
        wr(4'h3, 8'h7F);
        check("R9 unknown no stb", cmd_stb, 0);
        check("R4 unknown clears dma", dma_mode, 0);
        rd(4'h3, v); check("R9 unknown readback", v, 8'h7F);
        check("R10 len held unknown", xfer_len, 25'd5);
        wr(4'h3, 8'hC1);
        check("R9 select stb", cmd_stb, 1);
        check("R9 select op", cmd_op, 7'h41);
        check("R10 len held select", xfer_len, 25'd5);
        wr(4'h8, 8'h3C);
        rd(4'h8, v); check("R1 cfg1 writable", v, 8'h3C);
    endtask

    initial begin
        #150000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1; reg_wr = 0; reg_addr = 0; reg_wdata = 0; tc_event = 0; pend_size = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        t_reset();
        t_shadow();
        t_reload();
        t_nodma();
        t_flag();
        t_xfer();
        t_zero();
        t_unknown();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule